// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This unit holds a signed 64-bit accumulator split into a high word and a low word. Each accepted operation multiplies two signed operands and adds the product into the accumulator. The long form multiplies two full 32-bit operands. The word form multiplies the low 16 bits of each operand, after sign extension. A saturation input sets how the sum is formed and clamped, and the two forms clamp differently. The long form clamps the whole accumulator to a signed 48-bit range. The word form with saturation uses only the low word, and it reports an overflow by writing 1 into the high word.

The surrounding datapath can clear the accumulator or load either half from a 32-bit data input. It reads both halves directly. All results register on the clock edge that samples the request. No busy indication is needed.

Each cycle a priority selector turns the control inputs into one command. The commands are HOLD, CLEAR, LOAD and MAC. CLEAR wins over LOAD, LOAD wins over MAC, and HOLD applies when nothing is requested. The accumulator register then takes the value that the chosen command selects.

Top module: `satmac_unit`

## Requirements
- R1: After reset both accumulator halves read zero.
- R2: Long form (`op_word`=0) without saturation adds the signed 64-bit product of `op_a` and `op_b` to the 64-bit accumulator, with the sum wrapping modulo 2^64.
- R3: Long form with saturation (`sat_mode`=1) clamps the result to the range -2^47 to 2^47-1. A result inside that range is stored unchanged.
- R4: Long form with saturation: if the signed 64-bit addition overflows, the result is -2^47 when the old accumulator was negative and 2^47-1 otherwise.
- R5: Word form (`op_word`=1) uses only bits 15:0 of each operand. Both are sign-extended, giving a signed 32-bit product, and bits 31:16 have no effect.
- R6: Word form without saturation adds the sign-extended product to the full 64-bit accumulator, so carries reach the high word.
- R7: Word form with saturation adds the product to the low word alone. On signed 32-bit overflow the low word becomes 0x80000000 if the old low word was negative and 0x7FFFFFFF otherwise.
- R8: Word form with saturation writes 1 into the high word on overflow. Without overflow it leaves the high word unchanged.
- R9: `clr` zeroes both halves on the next edge and takes priority over both loads and any operation.
- R10: `ld_hi` and `ld_lo` load `ld_data` into the high or low half. Both may be set together. Any load suppresses an operation requested in the same cycle.
- R11: A result appears one clock after `op_valid`. With no request pending, both halves hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation request strobe |
| op_word | input | 1 | 1 = word form, 0 = long form |
| sat_mode | input | 1 | Saturating arithmetic select |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| clr | input | 1 | Synchronous clear of both halves |
| ld_hi | input | 1 | Load high half from ld_data |
| ld_lo | input | 1 | Load low half from ld_data |
| ld_data | input | 32 | Direct load data |
| acc_hi | output | 32 | Accumulator high word |
| acc_lo | output | 32 | Accumulator low word |

## Verification
R4 is the hardest case to reach from the ports. Saturated long operations keep the accumulator inside 48 bits, so saturated accumulation alone can never push the 64-bit sum into overflow. The stimulus reaches that case another way. It uses the direct loads to place the accumulator just below +2^63 or at -2^63, then issues a saturated long product of matching sign. In the positive case, a design that only clamped the wrapped sum would give the wrong end of the range. The word-form saturation edges are reached the same way: a preloaded high word shows whether it was kept or overwritten with 1.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic [1:0] {
        CMD_HOLD  = 2'd0,
        CMD_CLEAR = 2'd1,
        CMD_LOAD  = 2'd2,
        CMD_MAC   = 2'd3
    } mac_cmd_e;

endpackage

// File: rtl/mac_cmd_sel.sv
module mac_cmd_sel
    import mac_pkg::*;
(
    input  logic     clr,
    input  logic     ld_hi,
    input  logic     ld_lo,
    input  logic     op_valid,
    output mac_cmd_e cmd
);

    // Fixed priority: clear, then load, then accumulate.
    always_comb begin
        if (clr) begin
            cmd = CMD_CLEAR;
        end else if (ld_hi || ld_lo) begin
            cmd = CMD_LOAD;
        end else if (op_valid) begin
            cmd = CMD_MAC;
        end else begin
            cmd = CMD_HOLD;
        end
    end

endmodule

// File: rtl/mac_long_path.sv
module mac_long_path #(
    parameter int DATA_W   = 32,
    parameter int SAT_BITS = 48
) (
    input  logic [2*DATA_W-1:0] acc,
    input  logic [DATA_W-1:0]   op_a,
    input  logic [DATA_W-1:0]   op_b,
    input  logic                sat_mode,
    output logic [2*DATA_W-1:0] acc_next
);

    localparam int ACC_W = 2 * DATA_W;
    localparam logic signed [ACC_W-1:0] SAT_MAX =
        {{(ACC_W-SAT_BITS+1){1'b0}}, {(SAT_BITS-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] SAT_MIN = ~SAT_MAX;

    logic signed [ACC_W-1:0] ext_a;
    logic signed [ACC_W-1:0] ext_b;
    logic signed [ACC_W-1:0] prod;
    logic signed [ACC_W-1:0] sum;
    logic signed [ACC_W-1:0] acc_s;
    logic                    add_ovf;

    always_comb begin
        ext_a   = {{DATA_W{op_a[DATA_W-1]}}, op_a};
        ext_b   = {{DATA_W{op_b[DATA_W-1]}}, op_b};
        prod    = ext_a * ext_b;
        acc_s   = acc;
        sum     = acc_s + prod;
        add_ovf = (acc_s[ACC_W-1] == prod[ACC_W-1]) &&
                  (sum[ACC_W-1] != acc_s[ACC_W-1]);
    end

    // The addition overflow is checked first, so a sum that wrapped is never clamped.
    always_comb begin
        if (!sat_mode) begin
            acc_next = sum;
        end else if (add_ovf) begin
            acc_next = acc_s[ACC_W-1] ? SAT_MIN : SAT_MAX;
        end else if (sum > SAT_MAX) begin
            acc_next = SAT_MAX;
        end else if (sum < SAT_MIN) begin
            acc_next = SAT_MIN;
        end else begin
            acc_next = sum;
        end
    end

endmodule

// File: rtl/mac_word_path.sv
module mac_word_path #(
    parameter int DATA_W = 32
) (
    input  logic [2*DATA_W-1:0] acc,
    input  logic [DATA_W-1:0]   op_a,
    input  logic [DATA_W-1:0]   op_b,
    input  logic                sat_mode,
    output logic [2*DATA_W-1:0] acc_next
);

    localparam int ACC_W  = 2 * DATA_W;
    localparam int HALF_W = DATA_W / 2;
    localparam logic [DATA_W-1:0] WORD_MAX = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] WORD_MIN = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] OVF_MARK = DATA_W'(1);

    logic signed [DATA_W-1:0] half_a;
    logic signed [DATA_W-1:0] half_b;
    logic signed [DATA_W-1:0] prod;
    logic signed [DATA_W-1:0] lo_old;
    logic signed [DATA_W-1:0] lo_sum;
    logic [DATA_W-1:0]        hi_old;
    logic                     lo_ovf;
    logic signed [ACC_W-1:0]  prod_wide;

    always_comb begin
        half_a    = {{HALF_W{op_a[HALF_W-1]}}, op_a[HALF_W-1:0]};
        half_b    = {{HALF_W{op_b[HALF_W-1]}}, op_b[HALF_W-1:0]};
        prod      = half_a * half_b;
        prod_wide = {{DATA_W{prod[DATA_W-1]}}, prod};
        lo_old    = acc[DATA_W-1:0];
        hi_old    = acc[ACC_W-1:DATA_W];
        lo_sum    = lo_old + prod;
        lo_ovf    = (lo_old[DATA_W-1] == prod[DATA_W-1]) &&
                    (lo_sum[DATA_W-1] != lo_old[DATA_W-1]);
    end

    always_comb begin
        if (!sat_mode) begin
            acc_next = acc + prod_wide;
        end else if (lo_ovf) begin
            acc_next = {OVF_MARK, lo_old[DATA_W-1] ? WORD_MIN : WORD_MAX};
        end else begin
            acc_next = {hi_old, lo_sum};
        end
    end

endmodule

// File: rtl/satmac_unit.sv
module satmac_unit
    import mac_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int SAT_BITS = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic              op_word,
    input  logic              sat_mode,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              clr,
    input  logic              ld_hi,
    input  logic              ld_lo,
    input  logic [DATA_W-1:0] ld_data,
    output logic [DATA_W-1:0] acc_hi,
    output logic [DATA_W-1:0] acc_lo
);

    localparam int ACC_W = 2 * DATA_W;

    mac_cmd_e         cmd;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_d;
    logic [ACC_W-1:0] long_next;
    logic [ACC_W-1:0] word_next;

    mac_cmd_sel u_sel (
        .clr      (clr),
        .ld_hi    (ld_hi),
        .ld_lo    (ld_lo),
        .op_valid (op_valid),
        .cmd      (cmd)
    );

    mac_long_path #(
        .DATA_W   (DATA_W),
        .SAT_BITS (SAT_BITS)
    ) u_long (
        .acc      (acc_q),
        .op_a     (op_a),
        .op_b     (op_b),
        .sat_mode (sat_mode),
        .acc_next (long_next)
    );

    mac_word_path #(
        .DATA_W (DATA_W)
    ) u_word (
        .acc      (acc_q),
        .op_a     (op_a),
        .op_b     (op_b),
        .sat_mode (sat_mode),
        .acc_next (word_next)
    );

    always_comb begin
        acc_d = acc_q;
        unique case (cmd)
            CMD_HOLD:  acc_d = acc_q;
            CMD_CLEAR: acc_d = '0;
            CMD_LOAD: begin
                acc_d = acc_q;
                if (ld_hi) acc_d[ACC_W-1:DATA_W] = ld_data;
                if (ld_lo) acc_d[DATA_W-1:0]     = ld_data;
            end
            CMD_MAC:   acc_d = op_word ? word_next : long_next;
            default:   acc_d = acc_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    always_comb begin
        acc_hi = acc_q[ACC_W-1:DATA_W];
        acc_lo = acc_q[DATA_W-1:0];
    end

endmodule

// File: rtl/satmac_chk.sv
module satmac_chk #(
    parameter int DATA_W   = 32,
    parameter int SAT_BITS = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic              op_word,
    input logic              sat_mode,
    input logic              clr,
    input logic              ld_hi,
    input logic              ld_lo,
    input logic [DATA_W-1:0] ld_data,
    input logic [DATA_W-1:0] acc_hi,
    input logic [DATA_W-1:0] acc_lo
);

    localparam int ACC_W = 2 * DATA_W;
    localparam logic signed [ACC_W-1:0] RANGE_HI =
        {{(ACC_W-SAT_BITS+1){1'b0}}, {(SAT_BITS-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] RANGE_LO = ~RANGE_HI;

    logic                    mac_go;
    logic signed [ACC_W-1:0] acc_all;

    always_comb begin
        mac_go  = op_valid && !clr && !ld_hi && !ld_lo;
        acc_all = {acc_hi, acc_lo};
    end

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_hi == '0 && acc_lo == '0)); // R9

    AST_LOAD_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && ld_lo) |=> (acc_lo == $past(ld_data))); // R10

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !ld_hi && !ld_lo && !op_valid) |=> ($stable(acc_hi) && $stable(acc_lo))); // R11

    AST_LONG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_go && !op_word && sat_mode) |=> (acc_all <= RANGE_HI && acc_all >= RANGE_LO)); // R3

    AST_WORD_HI_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_go && op_word && sat_mode) |=> (acc_hi == $past(acc_hi) || acc_hi == DATA_W'(1))); // R8

endmodule

bind satmac_unit satmac_chk #(
    .DATA_W   (DATA_W),
    .SAT_BITS (SAT_BITS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_word  (op_word),
    .sat_mode (sat_mode),
    .clr      (clr),
    .ld_hi    (ld_hi),
    .ld_lo    (ld_lo),
    .ld_data  (ld_data),
    .acc_hi   (acc_hi),
    .acc_lo   (acc_lo)
);

// File: tb/sim_satmac_unit.sv
module sim_satmac_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_word = 1'b0;
    logic        sat_mode = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        clr = 1'b0;
    logic        ld_hi = 1'b0;
    logic        ld_lo = 1'b0;
    logic [31:0] ld_data = '0;
    logic [31:0] acc_hi;
    logic [31:0] acc_lo;

    int     n_checks = 0;
    int     n_fail = 0;
    longint model = 0;

    localparam longint S48_MAX = (64'sd1 <<< 47) - 64'sd1;
    localparam longint S48_MIN = -(64'sd1 <<< 47);

    always #2 clk = ~clk;

    satmac_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_word(op_word),
        .sat_mode(sat_mode), .op_a(op_a), .op_b(op_b), .clr(clr),
        .ld_hi(ld_hi), .ld_lo(ld_lo), .ld_data(ld_data),
        .acc_hi(acc_hi), .acc_lo(acc_lo)
    );

    task automatic compare(input string tag);
        logic [63:0] got;
        got = {acc_hi, acc_lo};
        n_checks++;
        if (got !== 64'(model)) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, 64'(model));
        end
    endtask

    // Behavioural next-state of the accumulator for one cycle of inputs.
    task automatic predict(input bit v, input bit w, input bit s, input logic [31:0] a,
                           input logic [31:0] b, input bit c, input bit lh, input bit ll,
                           input logic [31:0] d);
        longint p, sum, lo, ls;
        logic [63:0] m;
        m = 64'(model);
        if (c) begin
            m = '0;
        end else if (lh || ll) begin
            if (lh) m[63:32] = d;
            if (ll) m[31:0] = d;
        end else if (v && !w) begin
            p   = longint'($signed(a)) * longint'($signed(b));
            sum = model + p;
            if (!s) begin
                m = 64'(sum);
            end else if ((model < 0) == (p < 0) && (sum < 0) != (model < 0)) begin
                m = 64'((model < 0) ? S48_MIN : S48_MAX);
            end else if (sum > S48_MAX) begin
                m = 64'(S48_MAX);
            end else if (sum < S48_MIN) begin
                m = 64'(S48_MIN);
            end else begin
                m = 64'(sum);
            end
        end else if (v && w) begin
            p = longint'($signed(a[15:0])) * longint'($signed(b[15:0]));
            if (!s) begin
                m = 64'(model + p);
            end else begin
                lo = longint'($signed(m[31:0]));
                ls = lo + p;
                if (ls > 64'sd2147483647 || ls < -64'sd2147483648) begin
                    m[31:0]  = (lo < 0) ? 32'h8000_0000 : 32'h7fff_ffff;
                    m[63:32] = 32'd1;
                end else begin
                    m[31:0] = ls[31:0];
                end
            end
        end
        model = longint'(m);
    endtask

    task automatic step(input string tag, input bit v, input bit w, input bit s,
                        input logic [31:0] a, input logic [31:0] b, input bit c,
                        input bit lh, input bit ll, input logic [31:0] d);
        op_valid = v; op_word = w; sat_mode = s; op_a = a; op_b = b;
        clr = c; ld_hi = lh; ld_lo = ll; ld_data = d;
        predict(v, w, s, a, b, c, lh, ll, d);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic load(input string tag, input logic [31:0] hi, input logic [31:0] lo);
        step(tag, 0, 0, 0, '0, '0, 0, 1, 0, hi);
        step(tag, 0, 0, 0, '0, '0, 0, 0, 1, lo);
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model = 0;
        compare("R1 reset");
        step("R11 idle", 0, 0, 0, '0, '0, 0, 0, 0, '0);

        // R2 long, no saturation
        step("R2 small", 1, 0, 0, 32'd3, -32'sd5, 0, 0, 0, '0);
        step("R2 big", 1, 0, 0, 32'h7fff_ffff, 32'h8000_0000, 0, 0, 0, '0);
        load("R10 load", 32'h7fff_ffff, 32'hffff_ffff);
        step("R2 wrap", 1, 0, 0, 32'd1, 32'd1, 0, 0, 0, '0);

        // R3 clamp
        step("R9 clear", 0, 0, 0, '0, '0, 1, 0, 0, '0);
        step("R3 in range", 1, 0, 1, 32'd1000, -32'sd7, 0, 0, 0, '0);
        step("R3 clamp max", 1, 0, 1, 32'h7fff_ffff, 32'h7fff_ffff, 0, 0, 0, '0);
        step("R3 clamp min", 1, 0, 1, 32'h8000_0000, 32'h7fff_ffff, 0, 0, 0, '0);
        step("R3 clamp min2", 1, 0, 1, 32'h8000_0000, 32'h7fff_ffff, 0, 0, 0, '0);

        // R4 64-bit addition overflow
        load("R4 setup", 32'h7fff_ffff, 32'hffff_fff0);
        step("R4 pos ovf", 1, 0, 1, 32'h4000_0000, 32'h4000_0000, 0, 0, 0, '0);
        load("R4 setup", 32'h8000_0000, 32'h0000_0000);
        step("R4 neg ovf", 1, 0, 1, 32'h8000_0000, 32'h7fff_ffff, 0, 0, 0, '0);

        // R5 / R6 word form without saturation
        step("R9 clear", 0, 0, 0, '0, '0, 1, 0, 0, '0);
        step("R5 upper ignored", 1, 1, 0, 32'hABCD_0003, 32'h1234_FFFE, 0, 0, 0, '0);
        step("R5 min*min", 1, 1, 0, 32'h0000_8000, 32'hFFFF_8000, 0, 0, 0, '0);
        load("R6 setup", 32'h0000_0000, 32'hffff_ffff);
        step("R6 carry", 1, 1, 0, 32'd1, 32'd1, 0, 0, 0, '0);
        step("R6 borrow", 1, 1, 0, 32'd1, 32'hFFFF_FFFE, 0, 0, 0, '0);

        // R7 / R8 word form with saturation
        load("R8 setup", 32'd5, 32'h7fff_fff0);
        step("R8 no ovf keeps hi", 1, 1, 1, 32'd2, 32'd3, 0, 0, 0, '0);
        step("R7 pos ovf", 1, 1, 1, 32'h7fff, 32'h7fff, 0, 0, 0, '0);
        load("R7 setup", 32'h1234_5678, 32'h8000_0010);
        step("R7 neg ovf", 1, 1, 1, 32'h7fff, 32'hFFFF_8000, 0, 0, 0, '0);
        load("R7 setup", 32'hdead_beef, 32'hffff_fff0);
        step("R7 no ovf negative", 1, 1, 1, 32'h0003, 32'hFFFF_FFFB, 0, 0, 0, '0);

        // R9 / R10 priority
        step("R9 clear beats load", 1, 0, 0, 32'd9, 32'd9, 1, 1, 1, 32'h5555_5555);
        step("R10 load both", 0, 0, 0, '0, '0, 0, 1, 1, 32'h0000_0042);
        step("R10 load beats op", 1, 0, 0, 32'd100, 32'd100, 0, 0, 1, 32'h0000_0007);
        step("R10 hi load beats op", 1, 1, 1, 32'd100, 32'd100, 0, 1, 0, 32'h0000_0003);
        step("R11 hold", 0, 1, 1, 32'hffff_ffff, 32'hffff_ffff, 0, 0, 0, '0);

        // R11 mixed traffic compared every clock
        for (int i = 0; i < 400; i++) begin
            int unsigned r;
            logic [31:0] a;
            logic [31:0] b;
            r = $urandom;
            a = (r[3:2] == 2'd0) ? {r[4], 31'h7fff_ffff} ^ {32{r[5]}} : $urandom;
            b = (r[7:6] == 2'd0) ? 32'h7fff_ffff : $urandom;
            step("R11 mix", r[8] | r[9], r[10], r[11], a, b,
                 (r[15:12] == 4'd0), (r[19:16] == 4'd1), (r[19:16] == 4'd2), $urandom);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule